// File: doc/BRIEF.md
# Command/Address Parity Checker and Forwarder

This block sits between a memory controller and the DRAM devices of a registered memory module. On every rising clock edge where chip select is low it captures the command lines, bank group, bank, address and a parity bit. It then checks even parity over the captured lines. One clock later it drives the captured command onto its outputs. When checking is on and the parity is wrong, it drives a deselect instead.

A parity error pulls an active-low alert output low. The alert stays low until the DRAM recovery sequence reports that it has finished, through a recovery-done input. Checking is switched on and off by a bit in a control word held inside the block. The block writes this control word from a dedicated write command on the same command bus. That write command goes through the same parity check as any other command.

Top module: `ca_parity_fwd`

## Requirements
- R1: A command sampled with chip select low, correct parity and not a control-word write appears on the outputs one clock later. `cs_n_o` is low and the control lines, bank group, bank and address equal the sampled values.
- R2: A cycle with `cs_n_i` high is not sampled, whatever `par_i` is. One clock later the outputs show a deselect and the alert does not fall. A deselect means `cs_n_o` high, all four control lines high, and bank group, bank and address zero.
- R3: With checking enabled, a sampled command whose parity is wrong is replaced by a deselect one clock later.
- R4: With checking disabled, every sampled command is forwarded whatever its parity, and the alert does not fall.
- R5: A parity error while checking is enabled drives `alert_n_o` low one clock later. It stays low until `recov_done_i` is sampled high in a cycle with no new error. A new error in the same cycle as recovery-done keeps the alert low.
- R6: Parity is even. The XOR of `act_n_i`, `ras_n_i`, `cas_n_i`, `we_n_i`, `bg_i`, `ba_i`, `addr_i` and `par_i` must be 0. A single flipped bit in any of these lines is detected.
- R7: A control-word write has `act_n`=1, `ras_n`=0, `cas_n`=0, `we_n`=0, all bank group bits 1 and all bank bits 1. `addr[7:4]` selects the word and `addr[3:0]` carries its data. Bit 0 of word 4'hE enables checking. The write is consumed: the outputs show a deselect one clock later.
- R8: With checking enabled, a control-word write whose parity is wrong is not applied and raises the alert.
- R9: After reset, `cs_n_o` and all four control outputs are high, `alert_n_o` is high and checking is disabled.
- R10: A control-word write to any word other than 4'hE leaves the checking enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select from controller, active low |
| act_n_i | input | 1 | Activate line |
| ras_n_i | input | 1 | Row strobe / A16 line |
| cas_n_i | input | 1 | Column strobe / A15 line |
| we_n_i | input | 1 | Write enable / A14 line |
| bg_i | input | BG_W | Bank group |
| ba_i | input | BA_W | Bank address |
| addr_i | input | ADDR_W | Address A[ADDR_W-1:0] |
| par_i | input | 1 | Even parity bit over the covered lines |
| recov_done_i | input | 1 | DRAM recovery sequence finished |
| cs_n_o | output | 1 | Forwarded chip select |
| act_n_o | output | 1 | Forwarded activate line |
| ras_n_o | output | 1 | Forwarded row strobe / A16 |
| cas_n_o | output | 1 | Forwarded column strobe / A15 |
| we_n_o | output | 1 | Forwarded write enable / A14 |
| bg_o | output | BG_W | Forwarded bank group |
| ba_o | output | BA_W | Forwarded bank address |
| addr_o | output | ADDR_W | Forwarded address |
| alert_n_o | output | 1 | Parity alert, active low |

## Verification
The bench uses the default parameters: a 14-bit address, 2-bit bank group and 2-bit bank, with word 4'hE bit 0 as the enable. This keeps the covered vector at 22 bits. The bench therefore walks a single-bit parity flip through every covered line, including the high address bits, with checking on. With these values a control-word write decodes to bank group 3 and bank 3. This lets the bench aim legal and corrupted writes at the enable word and at another word, and watch the effect on later commands.

// File: rtl/ca_par_pkg.sv
package ca_par_pkg;
  typedef struct packed {
    logic act_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } ca_ctl_t;

  localparam int CTL_W    = 4;
  localparam int CW_SEL_W = 4;
  localparam int CW_DAT_W = 4;

  // control-word write: act high, ras/cas/we low
  localparam ca_ctl_t CW_CMD   = '{act_n: 1'b1, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
  localparam ca_ctl_t CTL_IDLE = '{act_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
endpackage

// File: rtl/ca_par_check.sv
module ca_par_check #(
  parameter int W = 22
) (
  input  logic [W-1:0] vec_i,
  input  logic         par_i,
  output logic         err_o
);
  // fold the vector as a chain so each stage is a 2-input XOR
  logic [W:0] acc;
  assign acc[0] = par_i;
  for (genvar i = 0; i < W; i++) begin : g_fold
    assign acc[i+1] = acc[i] ^ vec_i[i];
  end
  assign err_o = acc[W];
endmodule

// File: rtl/ca_cw_ctrl.sv
module ca_cw_ctrl
  import ca_par_pkg::*;
#(
  parameter int                    BG_W   = 2,
  parameter int                    BA_W   = 2,
  parameter logic [CW_SEL_W-1:0]   CW_IDX = 4'hE,
  parameter int                    EN_BIT = 0
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             sample_i,
  input  ca_ctl_t                          ctl_i,
  input  logic [BG_W-1:0]                  bg_i,
  input  logic [BA_W-1:0]                  ba_i,
  input  logic [CW_SEL_W+CW_DAT_W-1:0]     cw_addr_i,
  input  logic                             par_err_i,
  output logic                             is_cw_o,
  output logic                             chk_en_o
);
  logic apply;
  logic [CW_SEL_W-1:0] sel;
  logic [CW_DAT_W-1:0] dat;

  assign sel     = cw_addr_i[CW_SEL_W+CW_DAT_W-1:CW_DAT_W];
  assign dat     = cw_addr_i[CW_DAT_W-1:0];
  assign is_cw_o = sample_i && (ctl_i == CW_CMD) && (&bg_i) && (&ba_i);
  assign apply   = is_cw_o && !(chk_en_o && par_err_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      chk_en_o <= 1'b0;
    else if (apply && sel == CW_IDX)  chk_en_o <= dat[EN_BIT];
  end
endmodule

// File: rtl/ca_fwd_stage.sv
module ca_fwd_stage
  import ca_par_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BG_W   = 2,
  parameter int BA_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fwd_i,
  input  ca_ctl_t           ctl_i,
  input  logic [BG_W-1:0]   bg_i,
  input  logic [BA_W-1:0]   ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              cs_n_o,
  output ca_ctl_t           ctl_o,
  output logic [BG_W-1:0]   bg_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_o <= 1'b1;
      ctl_o  <= CTL_IDLE;
      bg_o   <= '0;
      ba_o   <= '0;
      addr_o <= '0;
    end else if (fwd_i) begin
      cs_n_o <= 1'b0;
      ctl_o  <= ctl_i;
      bg_o   <= bg_i;
      ba_o   <= ba_i;
      addr_o <= addr_i;
    end else begin
      cs_n_o <= 1'b1;
      ctl_o  <= CTL_IDLE;
      bg_o   <= '0;
      ba_o   <= '0;
      addr_o <= '0;
    end
  end
endmodule

// File: rtl/ca_alert_ctrl.sv
module ca_alert_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_i,
  input  logic recov_done_i,
  output logic alert_n_o
);
  // a fresh error outranks recovery-done
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           alert_n_o <= 1'b1;
    else if (err_i)        alert_n_o <= 1'b0;
    else if (recov_done_i) alert_n_o <= 1'b1;
  end
endmodule

// File: rtl/ca_parity_fwd.sv
module ca_parity_fwd
  import ca_par_pkg::*;
#(
  parameter int                  ADDR_W = 14,
  parameter int                  BG_W   = 2,
  parameter int                  BA_W   = 2,
  parameter logic [CW_SEL_W-1:0] CW_IDX = 4'hE,
  parameter int                  EN_BIT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              act_n_i,
  input  logic              ras_n_i,
  input  logic              cas_n_i,
  input  logic              we_n_i,
  input  logic [BG_W-1:0]   bg_i,
  input  logic [BA_W-1:0]   ba_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              par_i,
  input  logic              recov_done_i,
  output logic              cs_n_o,
  output logic              act_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BG_W-1:0]   bg_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              alert_n_o
);
  localparam int COV_W = CTL_W + BG_W + BA_W + ADDR_W;
  localparam int CWA_W = CW_SEL_W + CW_DAT_W;

  ca_ctl_t            ctl_w;
  ca_ctl_t            ctl_q;
  logic [COV_W-1:0]   cov_w;
  logic               sample_w;
  logic               par_err_w;
  logic               is_cw_w;
  logic               chk_en_w;
  logic               err_w;
  logic               fwd_w;

  assign ctl_w    = '{act_n: act_n_i, ras_n: ras_n_i, cas_n: cas_n_i, we_n: we_n_i};
  assign cov_w    = {ctl_w, bg_i, ba_i, addr_i};
  assign sample_w = !cs_n_i;

  ca_par_check #(.W(COV_W)) u_check (
    .vec_i (cov_w),
    .par_i (par_i),
    .err_o (par_err_w)
  );

  ca_cw_ctrl #(
    .BG_W(BG_W), .BA_W(BA_W), .CW_IDX(CW_IDX), .EN_BIT(EN_BIT)
  ) u_cw (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sample_i  (sample_w),
    .ctl_i     (ctl_w),
    .bg_i      (bg_i),
    .ba_i      (ba_i),
    .cw_addr_i (addr_i[CWA_W-1:0]),
    .par_err_i (par_err_w),
    .is_cw_o   (is_cw_w),
    .chk_en_o  (chk_en_w)
  );

  assign err_w = sample_w && chk_en_w && par_err_w;
  assign fwd_w = sample_w && !is_cw_w && !err_w;

  ca_fwd_stage #(.ADDR_W(ADDR_W), .BG_W(BG_W), .BA_W(BA_W)) u_fwd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fwd_i  (fwd_w),
    .ctl_i  (ctl_w),
    .bg_i   (bg_i),
    .ba_i   (ba_i),
    .addr_i (addr_i),
    .cs_n_o (cs_n_o),
    .ctl_o  (ctl_q),
    .bg_o   (bg_o),
    .ba_o   (ba_o),
    .addr_o (addr_o)
  );

  assign act_n_o = ctl_q.act_n;
  assign ras_n_o = ctl_q.ras_n;
  assign cas_n_o = ctl_q.cas_n;
  assign we_n_o  = ctl_q.we_n;

  ca_alert_ctrl u_alert (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .err_i        (err_w),
    .recov_done_i (recov_done_i),
    .alert_n_o    (alert_n_o)
  );
endmodule

// File: rtl/ca_parity_fwd_chk.sv
module ca_parity_fwd_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_n_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              recov_done_i,
  input logic              par_err,
  input logic              is_cw,
  input logic              chk_en,
  input logic              cs_n_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              alert_n_o
);
  a_r1_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_i && !par_err && !is_cw) |=> (!cs_n_o && addr_o == $past(addr_i)));

  a_r2_idle_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_i && alert_n_o) |=> (cs_n_o && alert_n_o));

  a_r3_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_i && chk_en && par_err) |=> cs_n_o);

  a_r4_pass_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_i && !chk_en && !is_cw) |=> !cs_n_o);

  a_r5_alert_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_i && chk_en && par_err) |=> !alert_n_o);

  a_r5_alert_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alert_n_o && !recov_done_i) |=> !alert_n_o);

  a_r7_cw_consumed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_cw |=> cs_n_o);

  a_r8_cw_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_cw && chk_en && par_err) |=> $stable(chk_en));
endmodule

bind ca_parity_fwd ca_parity_fwd_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_n_i       (cs_n_i),
  .addr_i       (addr_i),
  .recov_done_i (recov_done_i),
  .par_err      (par_err_w),
  .is_cw        (is_cw_w),
  .chk_en       (chk_en_w),
  .cs_n_o       (cs_n_o),
  .addr_o       (addr_o),
  .alert_n_o    (alert_n_o)
);

// File: tb/ca_parity_fwd_tb_top.sv
module ca_parity_fwd_tb_top;
  localparam int ADDR_W = 14;
  localparam int COV_W  = 4 + 2 + 2 + ADDR_W;
  localparam int OUT_W  = 1 + COV_W + 1;

  typedef struct {
    logic [OUT_W-1:0] val;
    string            tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, act_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] bg = '0, ba = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic par = 1'b0, recov = 1'b0;
  logic cs_n_o, act_n_o, ras_n_o, cas_n_o, we_n_o, alert_n_o;
  logic [1:0] bg_o, ba_o;
  logic [ADDR_W-1:0] addr_o;

  int checks = 0;
  int errors = 0;
  exp_t q[$];
  logic m_en = 1'b0;
  logic m_alert = 1'b1;

  always #5 clk = ~clk;

  ca_parity_fwd dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .act_n_i(act_n), .ras_n_i(ras_n),
    .cas_n_i(cas_n), .we_n_i(we_n), .bg_i(bg), .ba_i(ba), .addr_i(addr),
    .par_i(par), .recov_done_i(recov), .cs_n_o(cs_n_o), .act_n_o(act_n_o),
    .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o), .bg_o(bg_o),
    .ba_o(ba_o), .addr_o(addr_o), .alert_n_o(alert_n_o)
  );

  function automatic logic even_par(input logic [COV_W-1:0] v);
    return ^v;
  endfunction

  // vec layout: {act,ras,cas,we,bg[1:0],ba[1:0],addr}
  task automatic drive(input logic c, input logic [COV_W-1:0] v, input logic p,
                       input logic rc, input string tag);
    logic perr, is_cw;
    exp_t e;
    @(negedge clk);
    cs_n = c;
    {act_n, ras_n, cas_n, we_n, bg, ba, addr} = v;
    par = p;
    recov = rc;
    perr  = ^{v, p};
    is_cw = !c && v[COV_W-1 -: 4] == 4'b1000 && v[ADDR_W+3:ADDR_W] == 4'hF;
    if (!c && !is_cw && !(m_en && perr)) e.val = {1'b0, v, 1'b0};
    else e.val = {1'b1, 4'hF, 4'h0, {ADDR_W{1'b0}}, 1'b0};
    if (!c && m_en && perr) m_alert = 1'b0;
    else if (rc) m_alert = 1'b1;
    if (is_cw && !(m_en && perr) && v[7:4] == 4'hE) m_en = v[0];
    e.val[0] = m_alert;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic cmd(input logic [COV_W-1:0] v, input logic bad, input string tag);
    drive(1'b0, v, even_par(v) ^ bad, 1'b0, tag);
  endtask

  task automatic idle(input logic rc, input string tag);
    drive(1'b1, '0, 1'b1, rc, tag);
  endtask

  function automatic logic [COV_W-1:0] cw(input logic [3:0] sel, input logic [3:0] d);
    return {4'b1000, 2'b11, 2'b11, {(ADDR_W-8){1'b0}}, sel, d};
  endfunction

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      logic [OUT_W-1:0] act;
      e = q.pop_front();
      act = {cs_n_o, act_n_o, ras_n_o, cas_n_o, we_n_o, bg_o, ba_o, addr_o, alert_n_o};
      checks++;
      if (act !== e.val) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", e.tag, act, e.val);
      end
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #23;
    checks++;
    if ({cs_n_o, act_n_o, ras_n_o, cas_n_o, we_n_o} !== 5'h1F) begin
      errors++;
      $display("FAIL R9: actual %b expected 11111", {cs_n_o, act_n_o, ras_n_o, cas_n_o, we_n_o});
    end
    checks++;
    if (alert_n_o !== 1'b1) begin
      errors++;
      $display("FAIL R9 alert: actual %b expected 1", alert_n_o);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R9: checking off after reset, bad parity forwarded
    cmd({4'b0011, 2'b10, 2'b01, 14'h1234}, 1'b1, "R9 default disabled");
    // R1: good commands of several shapes
    cmd({4'b0111, 2'b01, 2'b10, 14'h0abc}, 1'b0, "R1 activate");
    cmd({4'b1101, 2'b11, 2'b00, 14'h3fff}, 1'b0, "R1 read");
    cmd({4'b1100, 2'b00, 2'b11, 14'h0001}, 1'b0, "R1 write");
    // R4: bad parity with checking disabled
    cmd({4'b1110, 2'b10, 2'b10, 14'h2aaa}, 1'b1, "R4 disabled bad parity");
    // R2: cs high, bad parity
    drive(1'b1, {4'b0000, 2'b11, 2'b11, 14'h1555}, 1'b1, 1'b0, "R2 cs high ignored");
    // R10: write to another word, enable stays off
    cmd(cw(4'h3, 4'h1), 1'b0, "R10 other word consumed");
    cmd({4'b1101, 2'b00, 2'b01, 14'h0f0f}, 1'b1, "R10 enable unchanged");
    // R7: enable checking
    cmd(cw(4'hE, 4'h1), 1'b0, "R7 enable write consumed");
    cmd({4'b1101, 2'b01, 2'b01, 14'h0333}, 1'b0, "R7 good after enable");
    // R3/R5: blocked, alert held
    cmd({4'b0101, 2'b10, 2'b00, 14'h0444}, 1'b1, "R3 blocked");
    idle(1'b0, "R5 alert held 1");
    idle(1'b0, "R5 alert held 2");
    cmd({4'b1100, 2'b00, 2'b00, 14'h0555}, 1'b0, "R5 held during good cmd");
    idle(1'b1, "R5 recovery releases");
    // R5: error and recovery in the same cycle
    drive(1'b0, {4'b1101, 2'b01, 2'b10, 14'h0666}, ~even_par({4'b1101, 2'b01, 2'b10, 14'h0666}),
          1'b1, "R5 error beats recovery");
    idle(1'b1, "R5 recovery after tie");
    // R6: walk a single flipped bit through every covered line
    for (int i = 0; i < COV_W; i++) begin
      logic [COV_W-1:0] base, v;
      base = {4'b1101, 2'b01, 2'b10, 14'h1a5c};
      v = base;
      v[i] = ~v[i];
      drive(1'b0, v, even_par(base), 1'b0, $sformatf("R6 flip bit %0d", i));
      idle(1'b1, "R6 recover");
    end
    // R8: corrupted disable write is rejected
    cmd(cw(4'hE, 4'h0), 1'b1, "R8 bad cw rejected");
    idle(1'b1, "R8 recover");
    cmd({4'b1100, 2'b11, 2'b01, 14'h0777}, 1'b1, "R8 still enabled");
    idle(1'b1, "R8 recover 2");
    // R7: good disable write, then bad parity passes
    cmd(cw(4'hE, 4'h0), 1'b0, "R7 disable write");
    cmd({4'b1100, 2'b11, 2'b01, 14'h0888}, 1'b1, "R7 disabled forwards");
    idle(1'b0, "R2 idle end");
    repeat (3) @(posedge clk);
    #4;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule